// File: doc/BRIEF.md
# Writeback Buffer Occupancy Stall Checker

This block decides whether an operation that produces a result may issue in the current cycle, based on how full a six-stage writeback buffer is. Each buffer stage has a busy flag and an 8-bit down-counter that says how many cycles that stage stays occupied. A requester presents a writeback horizon. For every busy stage, the block subtracts a fixed per-stage offset from that stage's counter and compares the result with the horizon. Any match raises `stall`.

A stall is a verdict for the current cycle only. The producer is held and presents the same request again on the following cycle, when the buffer may have drained. There are three request kinds:

- **Ordinary producer:** uses the horizon it supplies.
- **Store:** is also blocked while the writeback stage itself (stage 0) is occupied.
- **Half-to-full-width format conversion:** claims four writeback slots at once. All four slots share a fixed horizon of 14, so a single test at horizon 14 covers them.

Buffer stages are claimed through an allocate port. A drain tick ages every occupied stage by one cycle.

Top module: `wbuf_stall_check`

## Requirements
- R1: After reset every stage is idle: `busyVec` is 0, and `stall` is 0 for any check request.
- R2: Idle stages take no part in the check. With no stage busy, `stall` is 0 for every kind and every horizon.
- R3: Busy stage k conflicts when (counter − offset[k]) ≤ horizon. The offsets are 0, 2, 3, 4, 5, 6 for k = 0..5. `stall` is the OR of all conflicts, given in the same cycle as the request. It is evaluated anew every cycle, with no memory of earlier stalls.
- R4: The difference is signed. A counter smaller than its stage offset gives a negative value, which is ≤ any horizon and therefore stalls. It never wraps to a large positive value.
- R5: When `chkValid` is 0, `stall` is 0.
- R6: `chkKind` encoding: 2'b00 ordinary, 2'b01 store, 2'b10 widening conversion, 2'b11 treated as ordinary. A store also stalls whenever stage 0 is busy, whatever its counter.
- R7: A widening conversion compares against a fixed horizon of 14 and ignores `chkHorizon`.
- R8: An allocate request to an idle stage (index 0..5) with a nonzero count is accepted. From the next cycle that stage is busy and holds exactly that count, and the new count is not reduced by a drain tick in the same cycle.
- R9: An allocate request is refused, with `allocErr` high in the same cycle and the buffer unchanged, in three cases: the stage is already busy, the index is 6 or 7, or the count is zero.
- R10: On a drain tick every busy counter decreases by one. A stage whose counter reaches zero becomes idle. Without a tick, counters hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chkValid | input | 1 | A producer asks to issue this cycle |
| chkKind | input | 2 | Request kind (see R6) |
| chkHorizon | input | 8 | Requested writeback horizon |
| allocValid | input | 1 | Claim a buffer stage |
| allocStage | input | 3 | Stage index to claim |
| allocCount | input | 8 | Occupancy cycles for the claimed stage |
| drainTick | input | 1 | Age all busy stages by one |
| stall | output | 1 | Producer must hold this cycle |
| allocErr | output | 1 | Current allocate request is refused |
| busyVec | output | 6 | Busy flag of each stage |

## Verification
The bench aims at the edges of the per-stage offset test. These include a difference of exactly zero at stage 5, and counters below their offset that a design with an unsigned subtraction would wrap and silently let through. It also covers a store meeting a busy stage 0 with a far-off counter, where a design without the store rule would issue early, and widening conversions whose supplied horizon disagrees with 14. On the allocation side it covers double allocation, out-of-range indices and zero counts, where a careless design would overwrite a live entry or create a stage that never drains. Finally it covers an allocation in the same cycle as a drain tick, where a design that drains the fresh entry would end one cycle short.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  parameter int NUM_STAGES  = 6;
  parameter int CNT_W       = 8;
  localparam int STAGE_IDX_W = $clog2(NUM_STAGES);
  localparam int DIFF_W      = CNT_W + 2;

  typedef enum logic [1:0] {
    KIND_NORMAL = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_WIDE   = 2'b10,
    KIND_RSVD   = 2'b11
  } chk_kind_e;

  // Strobes handed from control to the stage datapath each cycle.
  typedef struct packed {
    logic [NUM_STAGES-1:0] allocOneHot;
    logic [CNT_W-1:0]      allocCount;
    logic                  drain;
    logic [CNT_W-1:0]      horizon;
  } wbuf_strobe_t;

  // Fixed per-stage distance: stage 0 sits at zero, later stages at k+1.
  function automatic logic [DIFF_W-1:0] stageOffset(input int k);
    return (k == 0) ? DIFF_W'(0) : DIFF_W'(k + 1);
  endfunction

endpackage

// File: rtl/wbuf_datapath.sv
module wbuf_datapath
  import wbuf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  wbuf_strobe_t          strb,
  output logic [NUM_STAGES-1:0] busyQ,
  output logic [NUM_STAGES-1:0] hitVec
);

  logic [CNT_W-1:0] cntQ [NUM_STAGES];
  logic signed [DIFF_W-1:0] horizonS;

  assign horizonS = $signed({2'b00, strb.horizon});

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    logic signed [DIFF_W-1:0] diffS;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyQ[k] <= 1'b0;
        cntQ[k]  <= '0;
      end else if (strb.allocOneHot[k]) begin
        busyQ[k] <= 1'b1;
        cntQ[k]  <= strb.allocCount;
      end else if (busyQ[k] && strb.drain) begin
        cntQ[k]  <= cntQ[k] - 1'b1;
        if (cntQ[k] == CNT_W'(1)) busyQ[k] <= 1'b0;
      end
    end

    assign diffS     = $signed({2'b00, cntQ[k]}) - $signed(stageOffset(k));
    assign hitVec[k] = busyQ[k] && (diffS <= horizonS);

    // R8
    alloc_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.allocOneHot[k] |=> busyQ[k] && cntQ[k] == $past(strb.allocCount));

    // R10
    drain_decrements_chk: assert property (@(posedge clk) disable iff (!rstN)
      busyQ[k] && strb.drain && !strb.allocOneHot[k] && cntQ[k] > CNT_W'(1)
      |=> busyQ[k] && cntQ[k] == $past(cntQ[k]) - 1'b1);

    // R10
    drain_retires_chk: assert property (@(posedge clk) disable iff (!rstN)
      busyQ[k] && strb.drain && !strb.allocOneHot[k] && cntQ[k] == CNT_W'(1)
      |=> !busyQ[k]);

    // R9
    busy_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
      busyQ[k] && !strb.drain |=> busyQ[k] && $stable(cntQ[k]));
  end

  // R8
  single_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.allocOneHot));

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int WIDE_HORIZON = 14,
  parameter int WB_STAGE     = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   chkValid,
  input  logic [1:0]             chkKind,
  input  logic [CNT_W-1:0]       chkHorizon,
  input  logic                   allocValid,
  input  logic [STAGE_IDX_W-1:0] allocStage,
  input  logic [CNT_W-1:0]       allocCount,
  input  logic                   drainTick,
  input  logic [NUM_STAGES-1:0]  busyQ,
  input  logic [NUM_STAGES-1:0]  hitVec,
  output wbuf_strobe_t           strb,
  output logic                   stall,
  output logic                   allocErr
);

  chk_kind_e kind;
  logic      stageInRange;
  logic      targetBusy;
  logic      storeBlock;

  assign kind         = chk_kind_e'(chkKind);
  assign stageInRange = (32'(allocStage) < NUM_STAGES);

  always_comb begin
    targetBusy = 1'b0;
    for (int k = 0; k < NUM_STAGES; k++)
      if (allocStage == STAGE_IDX_W'(k)) targetBusy = busyQ[k];
  end

  assign allocErr = allocValid &&
                    (!stageInRange || targetBusy || allocCount == '0);

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_dec
    assign strb.allocOneHot[k] = allocValid && !allocErr &&
                                 (allocStage == STAGE_IDX_W'(k));
  end

  assign strb.allocCount = allocCount;
  assign strb.drain      = drainTick;
  assign strb.horizon    = (kind == KIND_WIDE) ? CNT_W'(WIDE_HORIZON) : chkHorizon;

  assign storeBlock = (kind == KIND_STORE) && busyQ[WB_STAGE];
  assign stall      = chkValid && ((|hitVec) || storeBlock);

  // R2
  idle_never_stalls_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> busyQ != '0);

  // R9
  refused_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocErr |-> strb.allocOneHot == '0);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rstN) |-> busyQ == '0);

endmodule

// File: rtl/wbuf_stall_check.sv
module wbuf_stall_check
  import wbuf_pkg::*;
#(
  parameter int WIDE_HORIZON = 14,
  parameter int WB_STAGE     = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   chkValid,
  input  logic [1:0]             chkKind,
  input  logic [CNT_W-1:0]       chkHorizon,
  input  logic                   allocValid,
  input  logic [STAGE_IDX_W-1:0] allocStage,
  input  logic [CNT_W-1:0]       allocCount,
  input  logic                   drainTick,
  output logic                   stall,
  output logic                   allocErr,
  output logic [NUM_STAGES-1:0]  busyVec
);

  wbuf_strobe_t          strb;
  logic [NUM_STAGES-1:0] hitVec;

  wbuf_ctrl #(
    .WIDE_HORIZON(WIDE_HORIZON),
    .WB_STAGE    (WB_STAGE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chkValid  (chkValid),
    .chkKind   (chkKind),
    .chkHorizon(chkHorizon),
    .allocValid(allocValid),
    .allocStage(allocStage),
    .allocCount(allocCount),
    .drainTick (drainTick),
    .busyQ     (busyVec),
    .hitVec    (hitVec),
    .strb      (strb),
    .stall     (stall),
    .allocErr  (allocErr)
  );

  wbuf_datapath u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .busyQ (busyVec),
    .hitVec(hitVec)
  );

endmodule

// File: tb/wbuf_stall_check_tb.sv
module wbuf_stall_check_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chkValid = 1'b0;
  logic [1:0] chkKind = 2'b00;
  logic [7:0] chkHorizon = 8'd0;
  logic       allocValid = 1'b0;
  logic [2:0] allocStage = 3'd0;
  logic [7:0] allocCount = 8'd0;
  logic       drainTick = 1'b0;
  logic       stall;
  logic       allocErr;
  logic [5:0] busyVec;

  int checks = 0;
  int errors = 0;
  bit mBusy [6];
  int mCnt  [6];

  always #10 clk = ~clk;

  wbuf_stall_check u_dut (
    .clk(clk), .rstN(rstN), .chkValid(chkValid), .chkKind(chkKind),
    .chkHorizon(chkHorizon), .allocValid(allocValid), .allocStage(allocStage),
    .allocCount(allocCount), .drainTick(drainTick), .stall(stall),
    .allocErr(allocErr), .busyVec(busyVec)
  );

  function automatic int offs(input int k);
    return (k == 0) ? 0 : k + 1;
  endfunction

  function automatic bit expStall(input bit cv, input int kind, input int hor);
    int h = (kind == 2) ? 14 : hor;
    bit s = 0;
    for (int k = 0; k < 6; k++)
      if (mBusy[k] && (mCnt[k] - offs(k) <= h)) s = 1;
    if (kind == 1 && mBusy[0]) s = 1;
    return cv && s;
  endfunction

  function automatic bit expErr(input bit av, input int st, input int cnt);
    if (!av) return 0;
    return (st > 5) || (cnt == 0) || mBusy[st];
  endfunction

  function automatic string stallTag(input bit cv, input int kind, input int hor);
    bit anyBusy = 0;
    bit neg = 0;
    for (int k = 0; k < 6; k++) begin
      if (mBusy[k]) anyBusy = 1;
      if (mBusy[k] && mCnt[k] < offs(k)) neg = 1;
    end
    if (!cv) return "R5";
    if (!anyBusy) return "R2";
    if (kind == 2) return "R7";
    if (kind == 1 && mBusy[0]) return "R6";
    if (neg) return "R4";
    return "R3";
  endfunction

  function automatic logic [5:0] modelBusy();
    logic [5:0] v;
    for (int k = 0; k < 6; k++) v[k] = mBusy[k];
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doCycle(input bit cv, input int kind, input int hor,
                         input bit av, input int st, input int cnt, input bit dt);
    bit eS, eE;
    string tS;
    @(negedge clk);
    chkValid = cv; chkKind = 2'(kind); chkHorizon = 8'(hor);
    allocValid = av; allocStage = 3'(st); allocCount = 8'(cnt); drainTick = dt;
    #5;
    eS = expStall(cv, kind, hor);
    tS = stallTag(cv, kind, hor);
    eE = expErr(av, st, cnt);
    check(tS, int'(stall), int'(eS));
    check(eE ? "R9" : "R8", int'(allocErr), int'(eE));
    @(posedge clk);
    #1;
    for (int k = 0; k < 6; k++) begin
      if (av && !eE && st == k) begin
        mBusy[k] = 1; mCnt[k] = cnt;
      end else if (mBusy[k] && dt) begin
        mCnt[k]--;
        if (mCnt[k] == 0) mBusy[k] = 0;
      end
    end
    check(dt ? "R10" : "R8", int'(busyVec), int'(modelBusy()));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd7331);
    for (int k = 0; k < 6; k++) begin mBusy[k] = 0; mCnt[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: idle after reset
    @(negedge clk);
    check("R1", int'(busyVec), 0);
    chkValid = 1; chkHorizon = 8'd255;
    #1 check("R1", int'(stall), 0);
    // R2: every kind with nothing busy
    doCycle(1, 1, 255, 0, 0, 0, 0);
    doCycle(1, 2, 0, 0, 0, 0, 0);
    // R3: stage 5 count 6 gives difference 0
    doCycle(0, 0, 0, 1, 5, 6, 1);
    doCycle(1, 0, 0, 0, 0, 0, 0);
    // R9: double allocation, range and zero count refused
    doCycle(1, 0, 0, 1, 5, 9, 0);
    doCycle(0, 0, 0, 1, 6, 4, 0);
    doCycle(0, 0, 0, 1, 7, 4, 0);
    doCycle(0, 0, 0, 1, 2, 0, 0);
    // R4: drain stage 5 below its offset
    for (int i = 0; i < 4; i++) doCycle(1, 0, 0, 0, 0, 0, 1);
    doCycle(1, 0, 0, 0, 0, 0, 1);
    doCycle(1, 0, 0, 0, 0, 0, 1);
    // R6: store against stage 0 with far counter
    doCycle(0, 0, 0, 1, 0, 200, 0);
    doCycle(1, 1, 0, 0, 0, 0, 0);
    doCycle(1, 0, 0, 0, 0, 0, 0);
    doCycle(1, 3, 0, 0, 0, 0, 0);
    // R7: widening horizon fixed at 14
    doCycle(0, 0, 0, 1, 1, 16, 0);
    doCycle(1, 2, 255, 0, 0, 0, 0);
    doCycle(1, 2, 0, 0, 0, 0, 1);
    doCycle(1, 2, 0, 0, 0, 0, 0);
    // R8 + R10: allocate while draining
    doCycle(0, 0, 0, 1, 3, 2, 1);
    doCycle(1, 0, 0, 0, 0, 0, 1);
    doCycle(1, 0, 0, 0, 0, 0, 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      doCycle(($urandom % 4) != 0, $urandom % 4, $urandom % 24,
              ($urandom % 3) == 0, $urandom % 8, $urandom % 22,
              ($urandom % 5) < 3);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule